// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block forms the read data of an emulated parallel NOR flash. Each read strobe is answered one clock later with a word chosen by the current command mode. That word is one of four things: array contents from the storage read port, an identifier word or a protection code from autoselect decoding, the status byte, or an entry from the query table read port. The storage port and the query-table port are combinational lookups owned by the surrounding flash model. The command write sequencer supplies the mode code and the idle indication.

The block owns two pieces of state. The first is the status register: the sequencer loads it, and each status read inverts bit 6 so that software polling sees a toggling bit. The second is a small state machine with states DIRECT and COUNTING, which tracks whether the device sits in direct-array mode. Transition DIRECT->COUNTING is taken on a command start. Transition COUNTING->COUNTING counts each read made while the sequencer is idle. Transition COUNTING->DIRECT is taken once the count passes a limit of 42.

Top module: `flash_rd_resp`

## Requirements
- R1: After reset, rd_valid, mode_clr and rd_data are 0. rd_valid is high in exactly the cycle after a cycle with rd_en high. rd_data changes only on a strobed read and holds otherwise.
- R2: Mode code 0 is an array read: stor_addr equals rd_addr. With big_endian low, the byte at the lowest address lands in bits 7:0. With big_endian high, that byte lands in the most significant byte.
- R3: Mode code 1 is autoselect. The slot is rd_addr[7:0] shifted right by log2(DEV_BYTES). Slot 0 returns id0 and slot 1 returns id1, each truncated or zero-extended to the data width. Slot 2 returns 0.
- R4: In autoselect, slot 0x0E returns id2 and slot 0x0F returns id3. If that word's low byte is 0xFF, the read returns array data instead. Every other slot also returns array data.
- R5: Mode code 2 returns the status byte, zero-extended. Each such read inverts status bit 6 for the next read. Reads in other modes leave it unchanged. sts_load writes sts_val and takes priority over a toggle in the same cycle, while the read in that cycle still returns the old value.
- R6: Mode code 3 is a table query. cfi_idx carries the slot. A slot above 0x52 reads 0; any other slot returns cfi_rdata, zero-extended.
- R7: Mode codes 4 to 7 are served as an array read, and mode_clr goes high together with that read's rd_valid.
- R8: direct_mode is 1 after reset. A cmd_start pulse clears it in the next cycle and restarts the read count, including while already counting.
- R9: While direct_mode is 0, each read with seq_idle high is counted. The 43rd counted read sets direct_mode in the following cycle. Reads with seq_idle low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Static byte order for array reads |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Word-aligned byte offset |
| mode | input | 3 | Command mode code: 0 array, 1 autoselect, 2 status, 3 query |
| seq_idle | input | 1 | Sequencer is in its idle write cycle |
| cmd_start | input | 1 | First command write seen; leave direct-array mode |
| id0 | input | 16 | Identifier word for slot 0 |
| id1 | input | 16 | Identifier word for slot 1 |
| id2 | input | 16 | Identifier word for slot 0x0E |
| id3 | input | 16 | Identifier word for slot 0x0F |
| sts_load | input | 1 | Load the status register |
| sts_val | input | 8 | Value to load |
| stor_addr | output | ADDR_W | Storage read address |
| stor_rdata | input | 8*DEV_BYTES | Storage bytes, lowest address in bits 7:0 |
| cfi_idx | output | 8 | Query table index |
| cfi_rdata | input | 8 | Query table entry |
| rd_data | output | 8*DEV_BYTES | Registered read data |
| rd_valid | output | 1 | Read data valid |
| mode_clr | output | 1 | Request to return the sequencer to idle |
| direct_mode | output | 1 | Device is in direct-array mode |

## Verification
The assertions rely on the mode code, address and idle flag holding steady across the cycle in which rd_en is high. They also rely on the storage and table ports answering within that same cycle, and on cmd_start and sts_load being quiet during reset. The bench meets all of this by changing every input on the falling clock edge. Its storage and table models are pure functions of the address the block drives. The toggle-pair and lazy-return assertions therefore see stable, single-valued inputs at each rising edge.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam logic [2:0] MODE_ARRAY = 3'd0;
    localparam logic [2:0] MODE_IDSEL = 3'd1;
    localparam logic [2:0] MODE_STAT  = 3'd2;
    localparam logic [2:0] MODE_CFI   = 3'd3;

    localparam logic [7:0] CFI_LAST   = 8'h52;
    localparam logic [7:0] SLOT_ID2   = 8'h0E;
    localparam logic [7:0] SLOT_ID3   = 8'h0F;

    typedef enum logic [2:0] {
        SRC_ARRAY,
        SRC_ID,
        SRC_ZERO,
        SRC_STAT,
        SRC_CFI
    } resp_src_t;

    typedef enum logic {
        LZ_DIRECT,
        LZ_COUNTING
    } lazy_state_t;

    function automatic int unsigned width_shift(input int unsigned nbytes);
        return (nbytes >= 4) ? 2 : ((nbytes == 2) ? 1 : 0);
    endfunction

endpackage

// File: rtl/frd_slot_decode.sv
module frd_slot_decode
    import flash_rd_pkg::*;
#(
    parameter int unsigned DEV_BYTES = 2
) (
    input  logic [7:0]  addr_lo,
    input  logic [2:0]  mode,
    input  logic [15:0] id0,
    input  logic [15:0] id1,
    input  logic [15:0] id2,
    input  logic [15:0] id3,
    output logic [7:0]  boff,
    output resp_src_t   src,
    output logic [15:0] id_word,
    output logic        unknown
);
    localparam int unsigned SHIFT = width_shift(DEV_BYTES);

    always_comb begin
        boff    = addr_lo >> SHIFT;
        src     = SRC_ARRAY;
        id_word = '0;
        unknown = 1'b0;
        unique case (mode)
            MODE_ARRAY: src = SRC_ARRAY;
            MODE_IDSEL: begin
                unique case (boff)
                    8'h00:    begin src = SRC_ID; id_word = id0; end
                    8'h01:    begin src = SRC_ID; id_word = id1; end
                    8'h02:    src = SRC_ZERO;
                    SLOT_ID2: if (id2[7:0] != 8'hFF) begin src = SRC_ID; id_word = id2; end
                    SLOT_ID3: if (id3[7:0] != 8'hFF) begin src = SRC_ID; id_word = id3; end
                    default:  src = SRC_ARRAY;
                endcase
            end
            MODE_STAT:  src = SRC_STAT;
            MODE_CFI:   src = (boff > CFI_LAST) ? SRC_ZERO : SRC_CFI;
            default: begin
                src     = SRC_ARRAY;
                unknown = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/frd_status.sv
module frd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       stat_rd,
    output logic [7:0] sts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= 8'h00;
        end else if (load) begin
            sts <= load_val;
        end else if (stat_rd) begin
            sts <= sts ^ 8'h40;
        end
    end

    assert_toggle_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !load) |=> (sts[6] != $past(sts[6])));

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !load) |=> $stable(sts));
endmodule

// File: rtl/frd_lazy_fsm.sv
module frd_lazy_fsm
    import flash_rd_pkg::*;
#(
    parameter int unsigned LIMIT = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic rd_en,
    input  logic seq_idle,
    output logic direct_mode
);
    localparam int unsigned CW = $clog2(LIMIT + 2);

    lazy_state_t     state, state_nx;
    logic [CW-1:0]   cnt, cnt_nx;
    logic [CW-1:0]   cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            LZ_DIRECT: begin
                if (cmd_start) begin
                    state_nx = LZ_COUNTING;
                    cnt_nx   = '0;
                end
            end
            LZ_COUNTING: begin
                if (cmd_start) begin
                    cnt_nx = '0;
                end else if (rd_en && seq_idle) begin
                    if (cnt_inc > CW'(LIMIT)) begin
                        state_nx = LZ_DIRECT;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_inc;
                    end
                end
            end
            default: begin
                state_nx = LZ_DIRECT;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LZ_DIRECT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb direct_mode = (state == LZ_DIRECT);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LZ_COUNTING) |-> (cnt <= CW'(LIMIT)));

    assert_rise_needs_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(direct_mode) |-> $past(rd_en && seq_idle && !cmd_start));

    assert_fall_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(direct_mode) |-> $past(cmd_start));
endmodule

// File: rtl/flash_rd_resp.sv
module flash_rd_resp
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DEV_BYTES  = 2,
    parameter int unsigned LAZY_LIMIT = 42,
    localparam int unsigned DW        = 8 * DEV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [2:0]        mode,
    input  logic              seq_idle,
    input  logic              cmd_start,
    input  logic [15:0]       id0,
    input  logic [15:0]       id1,
    input  logic [15:0]       id2,
    input  logic [15:0]       id3,
    input  logic              sts_load,
    input  logic [7:0]        sts_val,
    output logic [ADDR_W-1:0] stor_addr,
    input  logic [DW-1:0]     stor_rdata,
    output logic [7:0]        cfi_idx,
    input  logic [7:0]        cfi_rdata,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              mode_clr,
    output logic              direct_mode
);
    localparam int unsigned IDW_USE = (DW < 16) ? DW : 16;

    resp_src_t   src;
    logic [7:0]  boff;
    logic [15:0] id_word;
    logic        unknown;
    logic [7:0]  sts;
    logic [DW-1:0] le_word, be_word, arr_word, resp;

    frd_slot_decode #(.DEV_BYTES(DEV_BYTES)) u_decode (
        .addr_lo (rd_addr[7:0]),
        .mode    (mode),
        .id0     (id0),
        .id1     (id1),
        .id2     (id2),
        .id3     (id3),
        .boff    (boff),
        .src     (src),
        .id_word (id_word),
        .unknown (unknown)
    );

    frd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sts_load),
        .load_val (sts_val),
        .stat_rd  (rd_en && (mode == MODE_STAT)),
        .sts      (sts)
    );

    frd_lazy_fsm #(.LIMIT(LAZY_LIMIT)) u_lazy (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .rd_en       (rd_en),
        .seq_idle    (seq_idle),
        .direct_mode (direct_mode)
    );

    assign stor_addr = rd_addr;
    assign cfi_idx   = boff;

    for (genvar i = 0; i < DEV_BYTES; i++) begin : g_lane
        assign le_word[8*i +: 8]               = stor_rdata[8*i +: 8];
        assign be_word[8*(DEV_BYTES-1-i) +: 8] = stor_rdata[8*i +: 8];
    end

    assign arr_word = big_endian ? be_word : le_word;

    always_comb begin
        resp = '0;
        unique case (src)
            SRC_ARRAY: resp = arr_word;
            SRC_ID:    for (int b = 0; b < IDW_USE; b++) resp[b] = id_word[b];
            SRC_ZERO:  resp = '0;
            SRC_STAT:  resp[7:0] = sts;
            SRC_CFI:   resp[7:0] = cfi_rdata;
            default:   resp = arr_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            mode_clr <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            mode_clr <= rd_en && unknown;
            if (rd_en) begin
                rd_data <= resp;
            end
        end
    end

    assert_valid_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_en));

    assert_data_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_clr_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |-> rd_valid);

    assert_cfi_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode == MODE_CFI) && (boff > CFI_LAST)) |=> (rd_data == '0));

    assert_status_pair_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode == MODE_STAT) && !sts_load && $past(rd_en && (mode == MODE_STAT) && !sts_load))
        |=> (rd_data[6] != $past(rd_data[6])));
endmodule

// File: tb/flash_rd_resp_bench.sv
module flash_rd_resp_bench;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DW     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              big_endian = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [2:0]        mode = 3'd0;
    logic              seq_idle = 1'b0;
    logic              cmd_start = 1'b0;
    logic              sts_load = 1'b0;
    logic [7:0]        sts_val = 8'h00;
    logic [ADDR_W-1:0] stor_addr;
    logic [DW-1:0]     stor_rdata;
    logic [7:0]        cfi_idx;
    logic [7:0]        cfi_rdata;
    logic [DW-1:0]     rd_data;
    logic              rd_valid;
    logic              mode_clr;
    logic              direct_mode;

    int nvec = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    // storage model: byte at address a is a[7:0] ^ 0x5A
    assign stor_rdata[7:0]  = stor_addr[7:0] ^ 8'h5A;
    assign stor_rdata[15:8] = (stor_addr[7:0] + 8'd1) ^ 8'h5A;
    assign cfi_rdata        = cfi_idx ^ 8'hC3;

    flash_rd_resp u_flash_rd_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .big_endian  (big_endian),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .mode        (mode),
        .seq_idle    (seq_idle),
        .cmd_start   (cmd_start),
        .id0         (16'h0001),
        .id1         (16'h227E),
        .id2         (16'h2210),
        .id3         (16'h00FF),
        .sts_load    (sts_load),
        .sts_val     (sts_val),
        .stor_addr   (stor_addr),
        .stor_rdata  (stor_rdata),
        .cfi_idx     (cfi_idx),
        .cfi_rdata   (cfi_rdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .mode_clr    (mode_clr),
        .direct_mode (direct_mode)
    );

    // {mode, addr, expected data}, little-endian
    localparam logic [34:0] VEC [14] = '{
        {3'd0, 16'h0010, 16'h4B4A},  // R2 array
        {3'd0, 16'h1234, 16'h6F6E},  // R2 array
        {3'd1, 16'h0000, 16'h0001},  // R3 slot 0
        {3'd1, 16'h0002, 16'h227E},  // R3 slot 1
        {3'd1, 16'h0004, 16'h0000},  // R3 slot 2
        {3'd1, 16'h001C, 16'h2210},  // R4 slot 0x0E
        {3'd1, 16'h001E, 16'h4544},  // R4 slot 0x0F unconfigured
        {3'd1, 16'h0100, 16'h0001},  // R3 upper bits ignored
        {3'd1, 16'h0006, 16'h5D5C},  // R4 other slot
        {3'd3, 16'h0020, 16'h00D3},  // R6 slot 0x10
        {3'd3, 16'h00A4, 16'h0091},  // R6 slot 0x52
        {3'd3, 16'h00A6, 16'h0000},  // R6 slot 0x53
        {3'd3, 16'h01FE, 16'h0000},  // R6 slot 0x7F
        {3'd5, 16'h0040, 16'h1B1A}   // R7 unknown mode
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] m, input logic [15:0] a, input logic idle);
        @(negedge clk);
        mode     = m;
        rd_addr  = a;
        seq_idle = idle;
        rd_en    = 1'b1;
        @(negedge clk);
        rd_en    = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 reset rd_data", 32'(rd_data), 32'd0);
        chk("R7 reset mode_clr", 32'(mode_clr), 32'd0);
        chk("R8 reset direct_mode", 32'(direct_mode), 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            do_read(VEC[i][34:32], VEC[i][31:16], 1'b0);
            chk("R1 valid", 32'(rd_valid), 32'd1);
            chk($sformatf("R2-R7 vector %0d data", i), 32'(rd_data), 32'(VEC[i][15:0]));
            chk("R7 mode_clr", 32'(mode_clr), 32'(VEC[i][34]));
        end

        // R1: no strobe, valid drops and data holds
        @(negedge clk);
        chk("R1 valid low", 32'(rd_valid), 32'd0);
        chk("R1 data held", 32'(rd_data), 32'h1B1A);

        // R2: big-endian assembly
        big_endian = 1'b1;
        do_read(3'd0, 16'h0010, 1'b0);
        chk("R2 big-endian", 32'(rd_data), 32'h4A4B);
        big_endian = 1'b0;

        // R5: status toggle
        @(negedge clk); sts_load = 1'b1; sts_val = 8'h80;
        @(negedge clk); sts_load = 1'b0;
        do_read(3'd2, 16'h0000, 1'b0);
        chk("R5 status first", 32'(rd_data), 32'h0080);
        do_read(3'd2, 16'h0000, 1'b0);
        chk("R5 status toggled", 32'(rd_data), 32'h00C0);
        do_read(3'd2, 16'h0000, 1'b0);
        chk("R5 status toggled back", 32'(rd_data), 32'h0080);
        @(negedge clk);
        sts_load = 1'b1; sts_val = 8'h11;
        mode = 3'd2; rd_en = 1'b1;
        @(negedge clk);
        sts_load = 1'b0; rd_en = 1'b0;
        chk("R5 load same cycle old value", 32'(rd_data), 32'h00C0);
        do_read(3'd2, 16'h0000, 1'b0);
        chk("R5 load wins over toggle", 32'(rd_data), 32'h0011);
        do_read(3'd0, 16'h0000, 1'b0);
        do_read(3'd2, 16'h0000, 1'b0);
        chk("R5 array read no toggle", 32'(rd_data), 32'h0051);

        // R8/R9: lazy return to direct-array mode
        pulse_start();
        chk("R8 leaves direct", 32'(direct_mode), 32'd0);
        for (int k = 0; k < 10; k++) do_read(3'd0, 16'h0000, 1'b1);
        pulse_start();
        for (int k = 0; k < 42; k++) do_read(3'd0, 16'h0000, 1'b1);
        do_read(3'd0, 16'h0000, 1'b0);
        chk("R9 after 42 counted reads", 32'(direct_mode), 32'd0);
        do_read(3'd0, 16'h0000, 1'b1);
        chk("R9 43rd counted read", 32'(direct_mode), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule